// File: doc/BRIEF.md
# Interrupt Dispatch Controller

This block sits beside a small 8-bit processor core and decides, at each instruction boundary, whether a hardware interrupt is taken instead of the next opcode fetch. It owns the global interrupt gate (the master enable), an 8-bit source-enable register and a 5-bit request register. Peripherals raise requests through a vector of set pulses, and software can overwrite the request and enable registers directly.

The decoder sends strobes for the enable-interrupts and disable-interrupts instructions. Enabling is always deferred: the gate drops at once and opens only at the following instruction boundary. Disabling is immediate in classic mode and deferred by one boundary in colour mode. When the gate is open at a boundary and some enabled source is requesting, the block emits a one-cycle take pulse with the jump address. It also clears that source's request bit, closes the gate and drops any deferred gate change. A separate sequencer pushes the return address. While the core is halted, a wake flag reports any enabled request, whatever the gate state.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After a synchronous reset the gate, the enable register, the request register, take_irq and wake are all zero.
- R2: The selected source is the lowest-numbered set bit of (en_q[4:0] & req_q). irq_vector is 0x40 + 8*n for source n, so the values are 0x40, 0x48, 0x50, 0x58 and 0x60.
- R3: take_irq is high for exactly one cycle, the cycle after an instr_boundary cycle in which ime was 1 and the pending set was non-zero. It is never high otherwise.
- R4: A dispatch clears the chosen request bit, clears ime and cancels any deferred gate change.
- R5: ei_stb clears ime on the next cycle and arms a deferred set. ime becomes 1 after the next instr_boundary, and no interrupt is taken at that boundary.
- R6: With color_mode=0, di_stb clears ime on the next cycle and cancels any deferred change.
- R7: With color_mode=1, di_stb leaves ime unchanged until the next instr_boundary. An interrupt can still be taken at that boundary. Otherwise ime is 0 after that boundary.
- R8: The enable register keeps all 8 written bits. Bits 7:5 never cause a dispatch.
- R9: A req_set bit sets its request bit. req_wr replaces the request register. A set pulse wins over a dispatch clear of the same bit in the same cycle.
- R10: wake is 1 one cycle after a cycle in which halted=1 and the pending set is non-zero, regardless of ime. Otherwise it is 0.
- R11: An ei_stb or di_stb that coincides with a dispatching boundary is discarded. When ei_stb and di_stb coincide, the disable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| color_mode | input | 1 | 1 selects the deferred disable behaviour |
| halted | input | 1 | Core is halted |
| instr_boundary | input | 1 | Core is at an instruction boundary |
| ei_stb | input | 1 | Enable-interrupts instruction executed |
| di_stb | input | 1 | Disable-interrupts instruction executed |
| req_set | input | 5 | Per-source request set pulses |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| req_wr | input | 1 | Write strobe for the request register |
| req_wdata | input | 5 | Request register write data |
| en_q | output | 8 | Enable register contents |
| req_q | output | 5 | Request register contents |
| ime | output | 1 | Master enable gate |
| take_irq | output | 1 | One-cycle dispatch pulse |
| irq_vector | output | 8 | Jump address, valid with take_irq |
| wake | output | 1 | Halted core has an enabled request |

## Verification
The selection logic is driven with single-source patterns for every source, which pins each vector value. Multi-bit patterns show that the lowest index wins and that the enable mask hides the lower requests. Patterns whose only enabled bits are 7:5 show that those bits are stored but never selected. Directed sequences run the gate timing for deferred enable, immediate disable and deferred disable, strobes that collide with a dispatch, a set pulse that collides with a clear, and wake while the gate is closed.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned IRQD_NSRC       = 5;
  localparam int unsigned IRQD_EN_W       = 8;
  localparam int unsigned IRQD_VEC_W      = 8;
  localparam int unsigned IRQD_VEC_BASE   = 'h40;
  localparam int unsigned IRQD_VEC_STRIDE = 8;

  // Deferred gate change waiting for the next instruction boundary
  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_ON   = 2'd1,
    ARM_OFF  = 2'd2
  } arm_e;
endpackage

// File: rtl/irqd_flag_regs.sv
module irqd_flag_regs #(
  parameter int unsigned NSRC = 5,
  parameter int unsigned EN_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_wr,
  input  logic [EN_W-1:0] en_wdata,
  input  logic            req_wr,
  input  logic [NSRC-1:0] req_wdata,
  input  logic [NSRC-1:0] req_set,
  input  logic [NSRC-1:0] clr_mask,
  output logic [EN_W-1:0] en_q,
  output logic [NSRC-1:0] req_q
);
  logic [NSRC-1:0] req_base;

  assign req_base = req_wr ? req_wdata : req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      req_q <= '0;
    end else begin
      if (en_wr) en_q <= en_wdata;
      req_q <= (req_base & ~clr_mask) | req_set;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_bit_chk
    p_req_sticky_r9 : assert property (@(posedge clk) disable iff (rst)
      req_set[i] |=> req_q[i]);
    p_clear_taken_r4 : assert property (@(posedge clk) disable iff (rst)
      (clr_mask[i] && !req_set[i] && !req_wr) |=> !req_q[i]);
  end
endmodule

// File: rtl/irqd_prio_sel.sv
module irqd_prio_sel #(
  parameter int unsigned NSRC       = 5,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned VEC_BASE   = 'h40,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic [NSRC-1:0]  pending,
  output logic             any,
  output logic [NSRC-1:0]  grant,
  output logic [VEC_W-1:0] vector
);
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [IDX_W-1:0] idx;

  // Walk from the top so the lowest set index is written last
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end

  assign any    = |pending;
  assign vector = VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STRIDE);
endmodule

// File: rtl/irqd_ime_ctrl.sv
module irqd_ime_ctrl
  import irqd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic color_mode,
  input  logic ei_stb,
  input  logic di_stb,
  input  logic boundary,
  input  logic take_now,
  output logic ime_q,
  output arm_e arm_q
);
  logic ime_d;
  arm_e arm_d;

  always_comb begin
    ime_d = ime_q;
    arm_d = arm_q;
    if (take_now) begin
      ime_d = 1'b0;
      arm_d = ARM_IDLE;
    end else begin
      if (boundary) begin
        case (arm_q)
          ARM_ON:  ime_d = 1'b1;
          ARM_OFF: ime_d = 1'b0;
          default: ime_d = ime_q;
        endcase
        arm_d = ARM_IDLE;
      end
      if (di_stb) begin
        if (color_mode) begin
          arm_d = ARM_OFF;
        end else begin
          ime_d = 1'b0;
          arm_d = ARM_IDLE;
        end
      end else if (ei_stb) begin
        ime_d = 1'b0;
        arm_d = ARM_ON;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ime_q <= 1'b0;
      arm_q <= ARM_IDLE;
    end else begin
      ime_q <= ime_d;
      arm_q <= arm_d;
    end
  end

  p_take_cancels_r4 : assert property (@(posedge clk) disable iff (rst)
    take_now |=> (!ime_q && arm_q == ARM_IDLE));
  p_ei_defers_r5 : assert property (@(posedge clk) disable iff (rst)
    (ei_stb && !di_stb && !take_now) |=> (!ime_q && arm_q == ARM_ON));
  p_armed_opens_r5 : assert property (@(posedge clk) disable iff (rst)
    (arm_q == ARM_ON && boundary && !take_now && !ei_stb && !di_stb) |=> ime_q);
  p_di_classic_r6 : assert property (@(posedge clk) disable iff (rst)
    (di_stb && !color_mode) |=> !ime_q);
  p_di_colour_holds_r7 : assert property (@(posedge clk) disable iff (rst)
    (di_stb && color_mode && !take_now && !boundary) |=> (ime_q == $past(ime_q)));
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irqd_pkg::*;
#(
  parameter int unsigned NSRC       = IRQD_NSRC,
  parameter int unsigned EN_W       = IRQD_EN_W,
  parameter int unsigned VEC_W      = IRQD_VEC_W,
  parameter int unsigned VEC_BASE   = IRQD_VEC_BASE,
  parameter int unsigned VEC_STRIDE = IRQD_VEC_STRIDE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             color_mode,
  input  logic             halted,
  input  logic             instr_boundary,
  input  logic             ei_stb,
  input  logic             di_stb,
  input  logic [NSRC-1:0]  req_set,
  input  logic             en_wr,
  input  logic [EN_W-1:0]  en_wdata,
  input  logic             req_wr,
  input  logic [NSRC-1:0]  req_wdata,
  output logic [EN_W-1:0]  en_q,
  output logic [NSRC-1:0]  req_q,
  output logic             ime,
  output logic             take_irq,
  output logic [VEC_W-1:0] irq_vector,
  output logic             wake
);
  localparam int unsigned VEC_LAST = VEC_BASE + (NSRC - 1) * VEC_STRIDE;

  logic [NSRC-1:0]  pending;
  logic [NSRC-1:0]  grant;
  logic [NSRC-1:0]  clr_mask;
  logic [VEC_W-1:0] sel_vec;
  logic             any_pend;
  logic             take_now;
  logic             ime_q;
  arm_e             arm_q;

  assign pending  = en_q[NSRC-1:0] & req_q;
  assign take_now = instr_boundary & ime_q & any_pend;
  assign clr_mask = take_now ? grant : '0;
  assign ime      = ime_q;

  irqd_flag_regs #(.NSRC(NSRC), .EN_W(EN_W)) u_flags (
    .clk(clk), .rst(rst),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .req_wr(req_wr), .req_wdata(req_wdata),
    .req_set(req_set), .clr_mask(clr_mask),
    .en_q(en_q), .req_q(req_q)
  );

  irqd_prio_sel #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
                  .VEC_STRIDE(VEC_STRIDE)) u_sel (
    .pending(pending), .any(any_pend), .grant(grant), .vector(sel_vec)
  );

  irqd_ime_ctrl u_gate (
    .clk(clk), .rst(rst), .color_mode(color_mode),
    .ei_stb(ei_stb), .di_stb(di_stb), .boundary(instr_boundary),
    .take_now(take_now), .ime_q(ime_q), .arm_q(arm_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_irq   <= 1'b0;
      irq_vector <= '0;
      wake       <= 1'b0;
    end else begin
      take_irq <= take_now;
      if (take_now) irq_vector <= sel_vec;
      wake <= halted & any_pend;
    end
  end

  p_grant_onehot_r2 : assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (any_pend == (grant != '0)));
  p_grant_lowest_r2 : assert property (@(posedge clk) disable iff (rst)
    any_pend |-> ((pending & (grant - NSRC'(1))) == '0));
  p_vec_range_r2 : assert property (@(posedge clk) disable iff (rst)
    take_irq |-> (irq_vector >= VEC_W'(VEC_BASE) && irq_vector <= VEC_W'(VEC_LAST)));
  p_take_cause_r3 : assert property (@(posedge clk) disable iff (rst)
    take_irq |-> $past(instr_boundary && ime_q && (pending != '0)));
  p_take_single_r3 : assert property (@(posedge clk) disable iff (rst)
    take_irq |=> !take_irq);
  p_high_en_inert_r8 : assert property (@(posedge clk) disable iff (rst)
    ((en_q[NSRC-1:0] & req_q) == '0) |=> !take_irq);
  p_wake_cause_r10 : assert property (@(posedge clk) disable iff (rst)
    wake |-> $past(halted));
endmodule

// File: tb/sim_irq_dispatch_ctrl.sv
`timescale 1ns/1ps
module sim_irq_dispatch_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       color_mode = 1'b0, halted = 1'b0, instr_boundary = 1'b0;
  logic       ei_stb = 1'b0, di_stb = 1'b0;
  logic [4:0] req_set = '0;
  logic       en_wr = 1'b0, req_wr = 1'b0;
  logic [7:0] en_wdata = '0;
  logic [4:0] req_wdata = '0;
  logic [7:0] en_q;
  logic [4:0] req_q;
  logic       ime, take_irq, wake;
  logic [7:0] irq_vector;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_dispatch_ctrl u0 (
    .clk(clk), .rst(rst), .color_mode(color_mode), .halted(halted),
    .instr_boundary(instr_boundary), .ei_stb(ei_stb), .di_stb(di_stb),
    .req_set(req_set), .en_wr(en_wr), .en_wdata(en_wdata),
    .req_wr(req_wr), .req_wdata(req_wdata), .en_q(en_q), .req_q(req_q),
    .ime(ime), .take_irq(take_irq), .irq_vector(irq_vector), .wake(wake)
  );

  // {enable[31:24], request[23:16], expect take[15:8], expect vector[7:0]}
  localparam logic [31:0] TBL [10] = '{
    32'h1F_01_01_40, 32'h1F_02_01_48, 32'h1F_04_01_50, 32'h1F_08_01_58,
    32'h1F_10_01_60, 32'h1F_1A_01_48, 32'h0C_1E_01_50,
    32'hE0_1F_00_00,   // only bits 7:5 enabled
    32'h10_0F_00_00,   // enabled source not requesting
    32'hFF_18_01_58
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_regs(input logic [7:0] en, input logic [4:0] rq);
    en_wr = 1'b1; en_wdata = en; req_wr = 1'b1; req_wdata = rq;
    step();
    en_wr = 1'b0; req_wr = 1'b0;
  endtask

  task automatic wr_req(input logic [4:0] rq);
    req_wr = 1'b1; req_wdata = rq;
    step();
    req_wr = 1'b0;
  endtask

  task automatic do_ei();
    ei_stb = 1'b1; step(); ei_stb = 1'b0;
  endtask

  task automatic do_di();
    di_stb = 1'b1; step(); di_stb = 1'b0;
  endtask

  task automatic do_bnd();
    instr_boundary = 1'b1; step(); instr_boundary = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 ime", int'(ime), 0);
    chk("R1 en_q", int'(en_q), 0);
    chk("R1 req_q", int'(req_q), 0);
    chk("R1 take", int'(take_irq), 0);
    chk("R1 wake", int'(wake), 0);

    // Table walk: R2 priority and vectors, R5 deferred enable, R8 high bits
    foreach (TBL[k]) begin
      logic [7:0] en_v, rq_v, vec_e;
      logic tk_e;
      en_v = TBL[k][31:24]; rq_v = TBL[k][23:16];
      tk_e = TBL[k][8];     vec_e = TBL[k][7:0];
      wr_regs(en_v, rq_v[4:0]);
      chk("R8 en readback", int'(en_q), int'(en_v));
      do_ei();
      chk("R5 ime off after ei", int'(ime), 0);
      do_bnd();
      chk("R5 no take at first boundary", int'(take_irq), 0);
      chk("R5 ime on after boundary", int'(ime), 1);
      do_bnd();
      chk("R2 take", int'(take_irq), int'(tk_e));
      if (tk_e) begin
        chk("R2 vector", int'(irq_vector), int'(vec_e));
        chk("R4 req cleared", int'(req_q),
            int'(rq_v[4:0] & ~(5'd1 << ((vec_e - 8'h40) >> 3))));
        chk("R4 ime cleared", int'(ime), 0);
      end else begin
        chk("R8 ime stays", int'(ime), 1);
        do_di();
      end
      step();
      chk("R3 single pulse", int'(take_irq), 0);
    end

    // R6 classic disable
    wr_regs(8'h1F, 5'h00);
    do_ei(); do_bnd();
    do_di();
    chk("R6 immediate off", int'(ime), 0);
    wr_req(5'h01);
    do_bnd();
    chk("R6 no take", int'(take_irq), 0);

    // R7 colour disable
    color_mode = 1'b1;
    wr_req(5'h00);
    do_ei(); do_bnd();
    do_di();
    chk("R7 ime held", int'(ime), 1);
    wr_req(5'h04);
    chk("R7 ime still held", int'(ime), 1);
    do_bnd();
    chk("R7 take at boundary", int'(take_irq), 1);
    chk("R7 vector", int'(irq_vector), 'h50);
    chk("R4 ime off after take", int'(ime), 0);
    do_ei(); do_bnd();
    do_di();
    do_bnd();
    chk("R7 off after boundary", int'(ime), 0);
    chk("R7 no take", int'(take_irq), 0);
    color_mode = 1'b0;

    // R9 request register
    wr_req(5'h00);
    req_set = 5'h08; step(); req_set = 5'h00;
    chk("R9 set pulse", int'(req_q), 'h08);
    wr_req(5'h03);
    chk("R9 write replaces", int'(req_q), 'h03);
    do_ei(); do_bnd();
    instr_boundary = 1'b1; req_set = 5'h01; step();
    instr_boundary = 1'b0; req_set = 5'h00;
    chk("R9 take", int'(take_irq), 1);
    chk("R9 vector", int'(irq_vector), 'h40);
    chk("R9 set beats clear", int'(req_q), 'h03);

    // R10 wake while gate closed
    halted = 1'b1;
    step(); step();
    chk("R10 wake", int'(wake), 1);
    chk("R10 ime closed", int'(ime), 0);
    wr_regs(8'h00, 5'h03);
    step();
    chk("R10 no pending no wake", int'(wake), 0);
    halted = 1'b0;
    wr_regs(8'h1F, 5'h03);
    step();
    chk("R10 not halted", int'(wake), 0);

    // R11 strobe collisions
    wr_req(5'h02);
    do_ei(); do_bnd();
    instr_boundary = 1'b1; ei_stb = 1'b1; step();
    instr_boundary = 1'b0; ei_stb = 1'b0;
    chk("R11 take", int'(take_irq), 1);
    chk("R11 vector", int'(irq_vector), 'h48);
    do_bnd();
    chk("R11 ei discarded", int'(ime), 0);
    wr_req(5'h00);
    ei_stb = 1'b1; di_stb = 1'b1; step();
    ei_stb = 1'b0; di_stb = 1'b0;
    do_bnd();
    chk("R11 di wins", int'(ime), 0);

    // R1 reset again clears state
    wr_regs(8'hFF, 5'h1F);
    do_ei(); do_bnd();
    rst = 1'b1; step(); rst = 1'b0; step();
    chk("R1 reset ime", int'(ime), 0);
    chk("R1 reset regs", int'({en_q, 3'b0, req_q}), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule